// File: doc/BRIEF.md
# Low-Power State Sequencer

This controller holds the power state of a chip that has three levels of operation: full-on, partial standby and deep standby. It drives one enable per power domain: the main logic, the standby GPIO lines 0 to 6, the standby coprocessor, the code SRAM and the wake circuitry. It also reports its state on a readable code. Entry into standby needs two steps. First the coprocessor signals that it is ready. Then the host issues a mode command. Return to full-on takes one of two paths: from partial standby the coprocessor asks for it once a wake source is pending, and from deep standby a filtered low level on the wake pin starts it.

Deep entry turns the domains off one per cycle, coprocessor first, then GPIO, then main. The deep wake turns them on in the reverse order. IR and RTC events are held in sticky flags until software clears them with a write-one-to-clear access. GPIO wake inputs count only in partial standby.

States, with their `state_o` codes: FULL_ON (0), PARTIAL (1), DEEP (2), DOWN_COP (3), DOWN_GPIO (4), UP_MAIN (5), UP_GPIO (6). Transitions:
- FULL_ON to PARTIAL on an accepted partial command.
- FULL_ON to DOWN_COP, then DOWN_GPIO, then DEEP on an accepted deep command.
- PARTIAL to FULL_ON on a qualified coprocessor wake request.
- DEEP to UP_MAIN, then UP_GPIO, then FULL_ON on a filtered wake-pin low.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset `state_o` is 0 (FULL_ON), all five enables are 1, `event_flags` is 0 and `wake_pending` is 0.
- R2: A mode command (`host_cmd_valid` high) is accepted only in FULL_ON, and only after a `cop_ready` pulse has been seen in FULL_ON. Code 2'b01 selects partial standby and 2'b10 selects deep standby. Codes 00 and 11 are ignored. An accepted command consumes the ready, so a later command needs a new ready pulse.
- R3: One cycle after an accepted partial command, `state_o` is 1. Only `en_cop`, `en_sram` and `en_gpio` are 1.
- R4: After an accepted deep command, the domains switch off on successive cycles. First `en_cop` goes off (state 3). Next `en_gpio` goes off (state 4). Last `en_main` goes off (state 2, DEEP). In DEEP only `en_sram` and `en_wake` are 1.
- R5: `wake_pin_n` passes a two-flop synchroniser and a filter of FILT_CYC (default 4) consecutive clock samples. A low level sampled on fewer edges is ignored. In DEEP an accepted low gives UP_MAIN (state 5, main on) 7 clock edges after the first low sample. UP_GPIO (state 6, GPIO on) follows one cycle later, then FULL_ON (coprocessor on) one cycle after that.
- R6: `event_flags` bit 0 (IR) and bit 1 (RTC) are set by `ir_evt` and `rtc_evt`. Each flag stays set until a cycle with `flag_clr_we` high and a 1 in the matching bit of `flag_clr_data`. A 0 bit has no effect. When a set and a clear hit the same flag in the same cycle, the set wins.
- R7: `wake_pending` is 1 when either flag is set. It is also 1 when any `gpio_wake` bit is 1 while in PARTIAL, and only then.
- R8: In PARTIAL, `cop_wake_req` with `wake_pending` high returns the state to FULL_ON on the next cycle, with all enables on. Without `wake_pending`, the request is ignored.
- R9: The following inputs leave the state and enables unchanged:
  - `cop_wake_req` outside PARTIAL.
  - `cop_ready` and mode commands outside FULL_ON.
  - The wake pin outside DEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cmd_valid | input | 1 | Host mode command strobe |
| host_cmd | input | 2 | Mode code: 01 partial, 10 deep |
| cop_ready | input | 1 | Coprocessor ready for standby |
| cop_wake_req | input | 1 | Coprocessor request to return to full-on |
| wake_pin_n | input | 1 | Asynchronous active-low wake pin |
| ir_evt | input | 1 | IR event pulse |
| rtc_evt | input | 1 | RTC expiry pulse |
| flag_clr_we | input | 1 | Flag clear write strobe |
| flag_clr_data | input | 2 | Write-one-to-clear mask {RTC, IR} |
| gpio_wake | input | 7 | GPIO wake inputs, lines 0 to 6 |
| en_main | output | 1 | Main domain enable |
| en_gpio | output | 1 | Standby GPIO domain enable |
| en_cop | output | 1 | Coprocessor domain enable |
| en_sram | output | 1 | Code SRAM enable |
| en_wake | output | 1 | Wake circuitry enable |
| state_o | output | 3 | Current state code |
| event_flags | output | 2 | Sticky flags {RTC, IR} |
| wake_pending | output | 1 | Qualified wake source present |

## Verification
A wrong state register shows up at once on `state_o` and on the five enables, because both are decoded from it in the same cycle. The bench therefore compares both after every edge of every power sequence. A lost or stale ready flag shows up one cycle after the next mode command, as an accepted or ignored command that should not have been. A miscounting filter shifts the wake sequence by whole cycles, or lets a short pulse through. That shows up 7 edges after the pin falls, when UP_MAIN is expected. Flag faults are visible immediately on `event_flags` and `wake_pending`.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_ON      = 3'd0,
        ST_PART    = 3'd1,
        ST_DEEP    = 3'd2,
        ST_DN_COP  = 3'd3,
        ST_DN_GPIO = 3'd4,
        ST_UP_MAIN = 3'd5,
        ST_UP_GPIO = 3'd6
    } pss_state_e;

    localparam logic [1:0] CMD_PART = 2'b01;
    localparam logic [1:0] CMD_DEEP = 2'b10;

    typedef struct packed {
        logic wake;
        logic main;
        logic gpio;
        logic cop;
        logic sram;
    } pss_dom_t;

endpackage

// File: rtl/pss_wake_filter.sv
module pss_wake_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic wake_low
);
    localparam int CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC - 1);

    logic        s1_q, s2_q;
    logic [CW-1:0] cnt_q;
    logic        low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            low_q <= 1'b0;
        end else if (s2_q) begin
            cnt_q <= '0;
            low_q <= 1'b0;
        end else begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX) low_q <= 1'b1;
        end
    end

    assign wake_low = low_q;

    // R5: the filtered low can only appear after a synchronised low sample
    assert_filter_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_q) |-> $past(!s2_q));

endmodule

// File: rtl/pss_evt_flags.sv
module pss_evt_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] evt,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_data,
    output logic [NF-1:0] flags
);
    generate
        for (genvar i = 0; i < NF; i++) begin : g_flag
            logic f_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    f_q <= 1'b0;
                else if (evt[i])               f_q <= 1'b1;
                else if (clr_we && clr_data[i]) f_q <= 1'b0;
            end
            assign flags[i] = f_q;

            // R6: write-one-to-clear empties the flag when no event arrives
            assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && clr_data[i] && !evt[i]) |=> !flags[i]);
            // R6: a set flag persists until cleared
            assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && !(clr_we && clr_data[i])) |=> flags[i]);
        end
    endgenerate

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pss_pkg::*;
#(
    parameter int FILT_CYC = 4,
    parameter int NGPIO    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cmd_valid,
    input  logic [1:0]       host_cmd,
    input  logic             cop_ready,
    input  logic             cop_wake_req,
    input  logic             wake_pin_n,
    input  logic             ir_evt,
    input  logic             rtc_evt,
    input  logic             flag_clr_we,
    input  logic [1:0]       flag_clr_data,
    input  logic [NGPIO-1:0] gpio_wake,
    output logic             en_main,
    output logic             en_gpio,
    output logic             en_cop,
    output logic             en_sram,
    output logic             en_wake,
    output logic [2:0]       state_o,
    output logic [1:0]       event_flags,
    output logic             wake_pending
);
    localparam int NFLAG = 2;

    pss_state_e st_q, st_d;
    logic       ready_q;
    logic       pin_wake;
    logic       accept;
    pss_dom_t   dom;

    pss_wake_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (wake_pin_n),
        .wake_low (pin_wake)
    );

    pss_evt_flags #(.NF(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      ({rtc_evt, ir_evt}),
        .clr_we   (flag_clr_we),
        .clr_data (flag_clr_data),
        .flags    (event_flags)
    );

    assign wake_pending = (|event_flags) || (st_q == ST_PART && |gpio_wake);
    assign accept = (st_q == ST_ON) && ready_q && host_cmd_valid &&
                    (host_cmd == CMD_PART || host_cmd == CMD_DEEP);

    // ready handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ready_q <= 1'b0;
        else if (accept)                     ready_q <= 1'b0;
        else if (st_q == ST_ON && cop_ready) ready_q <= 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ON;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ON:      if (accept) st_d = (host_cmd == CMD_PART) ? ST_PART : ST_DN_COP;
            ST_PART:    if (cop_wake_req && wake_pending) st_d = ST_ON;
            ST_DN_COP:  st_d = ST_DN_GPIO;
            ST_DN_GPIO: st_d = ST_DEEP;
            ST_DEEP:    if (pin_wake) st_d = ST_UP_MAIN;
            ST_UP_MAIN: st_d = ST_UP_GPIO;
            ST_UP_GPIO: st_d = ST_ON;
            default:    st_d = ST_ON;
        endcase
    end

    // outputs
    always_comb begin
        dom = '{wake: 1'b1, main: 1'b1, gpio: 1'b1, cop: 1'b1, sram: 1'b1};
        unique case (st_q)
            ST_ON:      dom = '{wake: 1'b1, main: 1'b1, gpio: 1'b1, cop: 1'b1, sram: 1'b1};
            ST_PART:    dom = '{wake: 1'b0, main: 1'b0, gpio: 1'b1, cop: 1'b1, sram: 1'b1};
            ST_DN_COP:  dom = '{wake: 1'b1, main: 1'b1, gpio: 1'b1, cop: 1'b0, sram: 1'b1};
            ST_DN_GPIO: dom = '{wake: 1'b1, main: 1'b1, gpio: 1'b0, cop: 1'b0, sram: 1'b1};
            ST_DEEP:    dom = '{wake: 1'b1, main: 1'b0, gpio: 1'b0, cop: 1'b0, sram: 1'b1};
            ST_UP_MAIN: dom = '{wake: 1'b1, main: 1'b1, gpio: 1'b0, cop: 1'b0, sram: 1'b1};
            ST_UP_GPIO: dom = '{wake: 1'b1, main: 1'b1, gpio: 1'b1, cop: 1'b0, sram: 1'b1};
            default:    dom = '{wake: 1'b1, main: 1'b1, gpio: 1'b1, cop: 1'b1, sram: 1'b1};
        endcase
    end

    assign en_main = dom.main;
    assign en_gpio = dom.gpio;
    assign en_cop  = dom.cop;
    assign en_sram = dom.sram;
    assign en_wake = dom.wake;
    assign state_o = st_q;

    // R4: the GPIO domain only drops after the coprocessor is already off
    assert_cop_off_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_gpio) |-> $past(!en_cop));
    // R5: GPIO comes back only once main was already on
    assert_gpio_after_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_gpio) |-> $past(en_main));
    // R5: coprocessor comes back only after GPIO and main
    assert_cop_last_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_cop) |-> ($past(en_gpio) && $past(en_main)));
    // R2: leaving full-on requires a recorded ready
    assert_entry_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ON && st_d != ST_ON) |-> ready_q);
    // R7: outside partial standby only the flags can raise a pending wake
    assert_gpio_partial_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pending && st_q != ST_PART) |-> (|event_flags));

endmodule

// File: tb/pwr_state_seq_tb_top.sv
module pwr_state_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cmd_valid = 1'b0;
    logic [1:0] host_cmd = 2'b00;
    logic       cop_ready = 1'b0;
    logic       cop_wake_req = 1'b0;
    logic       wake_pin_n = 1'b1;
    logic       ir_evt = 1'b0;
    logic       rtc_evt = 1'b0;
    logic       flag_clr_we = 1'b0;
    logic [1:0] flag_clr_data = 2'b00;
    logic [6:0] gpio_wake = '0;
    logic       en_main, en_gpio, en_cop, en_sram, en_wake;
    logic [2:0] state_o;
    logic [1:0] event_flags;
    logic       wake_pending;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pwr_state_seq dut_i (
        .clk(clk), .rst_n(rst_n), .host_cmd_valid(host_cmd_valid), .host_cmd(host_cmd),
        .cop_ready(cop_ready), .cop_wake_req(cop_wake_req), .wake_pin_n(wake_pin_n),
        .ir_evt(ir_evt), .rtc_evt(rtc_evt), .flag_clr_we(flag_clr_we),
        .flag_clr_data(flag_clr_data), .gpio_wake(gpio_wake), .en_main(en_main),
        .en_gpio(en_gpio), .en_cop(en_cop), .en_sram(en_sram), .en_wake(en_wake),
        .state_o(state_o), .event_flags(event_flags), .wake_pending(wake_pending)
    );

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // enables packed as {wake, main, gpio, cop, sram}
    function automatic logic [4:0] exp_en(input int st);
        case (st)
            0: return 5'b11111;
            1: return 5'b00111;
            2: return 5'b10001;
            3: return 5'b11101;
            4: return 5'b11001;
            5: return 5'b11001;
            6: return 5'b11101;
            default: return 5'b11111;
        endcase
    endfunction

    task automatic chk_st(input string req, input int st);
        logic [7:0] act, exp;
        act = {state_o, en_wake, en_main, en_gpio, en_cop, en_sram};
        exp = {3'(st), exp_en(st)};
        chk(act == exp, req, act, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        host_cmd_valid = 0; cop_ready = 0; cop_wake_req = 0; wake_pin_n = 1;
        ir_evt = 0; rtc_evt = 0; flag_clr_we = 0; flag_clr_data = 0; gpio_wake = 0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic ready_cmd(input logic [1:0] c);
        cop_ready = 1; step(); cop_ready = 0;
        host_cmd_valid = 1; host_cmd = c; step(); host_cmd_valid = 0;
    endtask

    initial begin
        do_reset();
        chk_st("R1 reset state", 0);
        chk({event_flags, wake_pending} == 3'b000, "R1 flags/pending", {event_flags, wake_pending}, 0);

        // R2: sweep ready x command code
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 4; c++) begin
                int es;
                do_reset();
                if (r == 1) begin cop_ready = 1; step(); cop_ready = 0; end
                host_cmd_valid = 1; host_cmd = 2'(c); step(); host_cmd_valid = 0;
                es = (r == 1 && c == 1) ? 1 : (r == 1 && c == 2) ? 3 : 0;
                chk_st("R2 handshake sweep", es);
            end
        end

        // R3 partial entry, R7 gpio sweep, R8 wake
        do_reset();
        ready_cmd(2'b01);
        chk_st("R3 partial enables", 1);
        for (int i = 0; i < 7; i++) begin
            gpio_wake = 7'(1 << i); #1;
            chk(wake_pending == 1'b1, "R7 gpio wake in partial", wake_pending, 1);
        end
        gpio_wake = 0; #1;
        chk(wake_pending == 1'b0, "R7 no source", wake_pending, 0);
        cop_wake_req = 1; step(); cop_wake_req = 0;
        chk_st("R8 wake without pending ignored", 1);
        // R9: ready, command and wake pin in partial
        cop_ready = 1; host_cmd_valid = 1; host_cmd = 2'b10; step();
        cop_ready = 0; host_cmd_valid = 0;
        wake_pin_n = 0; repeat (10) step(); wake_pin_n = 1;
        chk_st("R9 partial ignores cmd/ready/pin", 1);
        gpio_wake = 7'b0001000; cop_wake_req = 1; step(); cop_wake_req = 0; gpio_wake = 0;
        chk_st("R8 wake to full-on", 0);
        // R2 consumed ready, R9 ready in partial not recorded
        host_cmd_valid = 1; host_cmd = 2'b01; step(); host_cmd_valid = 0;
        chk_st("R2 ready consumed", 0);
        for (int i = 0; i < 7; i++) begin
            gpio_wake = 7'(1 << i); #1;
            chk(wake_pending == 1'b0, "R7 gpio ignored in full-on", wake_pending, 0);
        end
        gpio_wake = 0;
        cop_wake_req = 1; step(); cop_wake_req = 0;
        chk_st("R9 wake req in full-on ignored", 0);

        // R6 flags
        ir_evt = 1; step(); ir_evt = 0;
        chk(event_flags == 2'b01, "R6 IR set", event_flags, 2'b01);
        chk(wake_pending == 1'b1, "R7 flag pending", wake_pending, 1);
        flag_clr_we = 1; flag_clr_data = 2'b10; step(); flag_clr_we = 0;
        chk(event_flags == 2'b01, "R6 zero bit no effect", event_flags, 2'b01);
        rtc_evt = 1; step(); rtc_evt = 0;
        chk(event_flags == 2'b11, "R6 RTC set", event_flags, 2'b11);
        flag_clr_we = 1; flag_clr_data = 2'b01; step(); flag_clr_we = 0;
        chk(event_flags == 2'b10, "R6 clear IR", event_flags, 2'b10);
        rtc_evt = 1; flag_clr_we = 1; flag_clr_data = 2'b10; step();
        rtc_evt = 0; flag_clr_we = 0;
        chk(event_flags == 2'b10, "R6 set wins", event_flags, 2'b10);
        flag_clr_we = 1; flag_clr_data = 2'b11; step(); flag_clr_we = 0;
        chk(event_flags == 2'b00, "R6 clear all", event_flags, 0);

        // R4 deep entry sequence
        ready_cmd(2'b10);
        chk_st("R4 coprocessor off", 3);
        step(); chk_st("R4 gpio off", 4);
        step(); chk_st("R4 main off", 2);
        ir_evt = 1; step(); ir_evt = 0;
        cop_wake_req = 1; step(); cop_wake_req = 0; step();
        chk_st("R9 wake req in deep ignored", 2);
        flag_clr_we = 1; flag_clr_data = 2'b11; step(); flag_clr_we = 0;

        // R5 filter sweep over pulse lengths
        for (int L = 1; L <= 6; L++) begin
            wake_pin_n = 0;
            for (int k = 1; k <= 6; k++) begin
                step();
                if (k == L) wake_pin_n = 1;
            end
            step();
            if (L >= 4) begin
                chk_st("R5 up main", 5);
                step(); chk_st("R5 up gpio", 6);
                step(); chk_st("R5 full-on", 0);
                ready_cmd(2'b10); step(); step();
                chk_st("R4 re-enter deep", 2);
            end else begin
                chk_st("R5 short pulse rejected", 2);
                repeat (8) step();
                chk_st("R5 short pulse still deep", 2);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule